// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Matcher

The block holds three alarm registers (minutes, hours, day of week) that a host reads and writes over a byte-wide register port. It compares them against the running time supplied by an external timekeeper. When the selected fields agree, it raises a sticky alarm flag and an interrupt.

Bit 7 of each alarm register is a mask bit, and the masks act cumulatively from the day register downward. With the day unmasked, the alarm needs a full match. Masking the day gives a daily alarm, masking the hours as well gives an hourly alarm, and masking all three gives an alarm every minute. The time comparison is evaluated on a strobe that marks the last hundredth of each second. The per-minute alarm instead uses a strobe that marks the seconds rolling over from 59 to 00. Any host read or write of an alarm register clears the flag and the interrupt.

Top module: `tm_alarm_matcher`

## Requirements
- R1: After reset, alarm_o and irq_o are 0 and the three alarm registers (addresses 3, 5 and 7) read 0.
- R2: Register port: a cycle with acc_i=1 and we_i=1 writes wdata_i. Address 3 (minutes) and address 5 (hours) keep all 8 bits. Address 7 (day) keeps bits 7 and 2:0, and its bits 6:3 always read 0. rdata_o shows the register selected by addr_i combinationally.
- R3: Any other address reads 0. A write to it changes no alarm register, and an access to it does not clear the flag.
- R4: With the day mask (address 7 bit 7) at 0, an eval_i cycle sets the flag when all three of these hold: minutes bits 6:0 equal, hours bits 6:0 equal, and day bits 2:0 equal. The minute and hour mask bits have no effect in this case.
- R5: With the day mask at 1 and the hour mask (address 5 bit 7) at 0, an eval_i cycle sets the flag when minutes and hours match. The day is ignored.
- R6: With the day and hour masks at 1 and the minute mask (address 3 bit 7) at 0, an eval_i cycle sets the flag when the minutes match.
- R7: With all three masks at 1, the flag is set by a sec_roll_i cycle, and eval_i has no effect.
- R8: The hours comparison includes bit 6 (12/24-hour select) and bit 5 (AM/PM or tens of hours) exactly as stored.
- R9: The flag is set one clock after the qualifying cycle and stays set until it is cleared. irq_o always equals alarm_o.
- R10: A cycle with acc_i=1 at address 3, 5 or 7 clears the flag from the next clock, whether it is a read or a write. If the same cycle also sets the flag, the set wins. A write in that cycle is compared using the register values held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| cur_min_i | input | 8 | Current minutes, BCD |
| cur_hour_i | input | 8 | Current hours, BCD with mode bits |
| cur_day_i | input | 8 | Current day of week |
| eval_i | input | 1 | Evaluation strobe (hundredths at 99) |
| sec_roll_i | input | 1 | Seconds rollover strobe (59 to 00) |
| alarm_o | output | 1 | Sticky alarm flag |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The bench uses mask combinations that are not listed as modes, such as minute and hour masks set while the day mask is clear. A decoder that read the masks independently would then drop fields from the comparison and fire early. Hour values that differ only in the AM/PM or 12/24 bit catch a comparator that trims the hours field. A per-minute setup with a matching eval_i catches a design that keeps using the wrong strobe. Cycles where an access and a set coincide, and accesses to addresses other than 3, 5 and 7, separate a correct clear priority and address decode from a design that loses alarms or clears the flag on any access.

// File: rtl/tm_alarm_pkg.sv
package tm_alarm_pkg;
  typedef enum logic [1:0] {
    MODE_FULL    = 2'd0,
    MODE_DAILY   = 2'd1,
    MODE_HOURLY  = 2'd2,
    MODE_MINUTE  = 2'd3
  } alarm_mode_e;
endpackage

// File: rtl/tm_alarm_regs.sv
module tm_alarm_regs #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int DAY_W     = 3,
  parameter int ADDR_MIN  = 3,
  parameter int ADDR_HOUR = 5,
  parameter int ADDR_DAY  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              hit_o,
  output logic [DATA_W-1:0] min_o,
  output logic [DATA_W-1:0] hour_o,
  output logic [DATA_W-1:0] day_o
);
  localparam int NREG = 3;
  localparam logic [DATA_W-1:0] MSB_M = DATA_W'(1) << (DATA_W-1);
  localparam logic [DATA_W-1:0] DAY_KEEP = MSB_M | DATA_W'((1 << DAY_W) - 1);
  localparam logic [DATA_W-1:0] FULL_KEEP = '1;
  localparam logic [ADDR_W-1:0] REG_ADDR [NREG] = '{
    ADDR_W'(ADDR_MIN), ADDR_W'(ADDR_HOUR), ADDR_W'(ADDR_DAY)};
  localparam logic [DATA_W-1:0] REG_KEEP [NREG] = '{FULL_KEEP, FULL_KEEP, DAY_KEEP};

  logic [DATA_W-1:0] reg_q [NREG];
  logic [NREG-1:0]   sel;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign sel[g] = (addr_i == REG_ADDR[g]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   reg_q[g] <= '0;
      else if (acc_i && we_i && sel[g]) reg_q[g] <= wdata_i & REG_KEEP[g];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++)
      if (sel[i]) rdata_o = reg_q[i];
  end

  assign hit_o  = acc_i && (|sel);
  assign min_o  = reg_q[0];
  assign hour_o = reg_q[1];
  assign day_o  = reg_q[2];

  // R2
  min_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && we_i && addr_i == ADDR_W'(ADDR_MIN) |=> min_o == $past(wdata_i));
  // R3
  no_stray_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |=> $stable(min_o) && $stable(hour_o) && $stable(day_o));
endmodule

// File: rtl/tm_alarm_match.sv
module tm_alarm_match
  import tm_alarm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DAY_W  = 3
) (
  input  logic [DATA_W-1:0] al_min_i,
  input  logic [DATA_W-1:0] al_hour_i,
  input  logic [DATA_W-1:0] al_day_i,
  input  logic [DATA_W-1:0] cur_min_i,
  input  logic [DATA_W-1:0] cur_hour_i,
  input  logic [DATA_W-1:0] cur_day_i,
  input  logic              eval_i,
  input  logic              sec_roll_i,
  output alarm_mode_e       mode_o,
  output logic              set_o
);
  localparam int F_W = DATA_W - 1;

  logic min_eq, hour_eq, day_eq, hit;

  assign min_eq  = al_min_i[F_W-1:0]  == cur_min_i[F_W-1:0];
  assign hour_eq = al_hour_i[F_W-1:0] == cur_hour_i[F_W-1:0];
  assign day_eq  = al_day_i[DAY_W-1:0] == cur_day_i[DAY_W-1:0];

  // cumulative masks: lower masks only count once the ones above are set
  always_comb begin
    if (!al_day_i[F_W])       mode_o = MODE_FULL;
    else if (!al_hour_i[F_W]) mode_o = MODE_DAILY;
    else if (!al_min_i[F_W])  mode_o = MODE_HOURLY;
    else                      mode_o = MODE_MINUTE;
  end

  always_comb begin
    unique case (mode_o)
      MODE_FULL:   hit = eval_i && min_eq && hour_eq && day_eq;
      MODE_DAILY:  hit = eval_i && min_eq && hour_eq;
      MODE_HOURLY: hit = eval_i && min_eq;
      default:     hit = sec_roll_i;
    endcase
  end

  assign set_o = hit;
endmodule

// File: rtl/tm_alarm_flag.sv
module tm_alarm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  // R10
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> !flag_o);
  // R9
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !clr_i |=> flag_o);
  // R9
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_o && !set_i |=> !flag_o);
endmodule

// File: rtl/tm_alarm_matcher.sv
module tm_alarm_matcher
  import tm_alarm_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int DAY_W     = 3,
  parameter int ADDR_MIN  = 3,
  parameter int ADDR_HOUR = 5,
  parameter int ADDR_DAY  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] cur_min_i,
  input  logic [DATA_W-1:0] cur_hour_i,
  input  logic [DATA_W-1:0] cur_day_i,
  input  logic              eval_i,
  input  logic              sec_roll_i,
  output logic              alarm_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] al_min, al_hour, al_day;
  logic              hit, set;
  alarm_mode_e       mode;

  tm_alarm_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DAY_W(DAY_W),
    .ADDR_MIN(ADDR_MIN), .ADDR_HOUR(ADDR_HOUR), .ADDR_DAY(ADDR_DAY)
  ) u_regs (
    .clk_i, .rst_ni, .acc_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .hit_o(hit), .min_o(al_min), .hour_o(al_hour), .day_o(al_day)
  );

  tm_alarm_match #(.DATA_W(DATA_W), .DAY_W(DAY_W)) u_match (
    .al_min_i(al_min), .al_hour_i(al_hour), .al_day_i(al_day),
    .cur_min_i, .cur_hour_i, .cur_day_i, .eval_i, .sec_roll_i,
    .mode_o(mode), .set_o(set)
  );

  tm_alarm_flag u_flag (
    .clk_i, .rst_ni, .set_i(set), .clr_i(hit), .flag_o(alarm_o)
  );

  assign irq_o = alarm_o;

  // R7
  per_minute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    al_min[DATA_W-1] && al_hour[DATA_W-1] && al_day[DATA_W-1]
      && !sec_roll_i && !alarm_o |=> !alarm_o);
  // R4
  full_needs_eval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !al_day[DATA_W-1] && !eval_i && !alarm_o |=> !alarm_o);
endmodule

// File: tb/tm_alarm_matcher_tb.sv
`timescale 1ns/1ps
module tm_alarm_matcher_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [7:0] cmin = '0, chour = '0, cday = '0;
  logic       ev = 1'b0, roll = 1'b0;
  logic       alarm, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_min = '0, m_hour = '0, m_day = '0;
  bit         m_flag = 0;

  always #4 clk = ~clk;

  tm_alarm_matcher u_dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_i(acc), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cur_min_i(cmin), .cur_hour_i(chour),
    .cur_day_i(cday), .eval_i(ev), .sec_roll_i(roll), .alarm_o(alarm), .irq_o(irq)
  );

  function automatic logic [7:0] m_read(input logic [3:0] a);
    case (a)
      4'd3:    return m_min;
      4'd5:    return m_hour;
      4'd7:    return m_day & 8'h87;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit m_set();
    bit mm = (m_min[6:0] == cmin[6:0]);
    bit hm = (m_hour[6:0] == chour[6:0]);
    bit dm = (m_day[2:0] == cday[2:0]);
    if (!m_day[7])  return ev && mm && hm && dm;
    if (!m_hour[7]) return ev && mm && hm;
    if (!m_min[7])  return ev && mm;
    return roll;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle, compare outputs, then advance the model across the edge
  task automatic step(input bit a, input bit w, input logic [3:0] ad, input logic [7:0] wd,
                      input logic [7:0] mi, input logic [7:0] hr, input logic [7:0] dy,
                      input bit e, input bit r, input string tag);
    bit s, c;
    acc = a; we = w; addr = ad; wdata = wd;
    cmin = mi; chour = hr; cday = dy; ev = e; roll = r;
    #1;
    chk({tag, " rdata"}, rdata, m_read(ad));
    chk({tag, " alarm"}, {7'd0, alarm}, {7'd0, m_flag});
    chk({"R9 irq"}, {7'd0, irq}, {7'd0, alarm});
    s = m_set();
    c = a && (ad == 4'd3 || ad == 4'd5 || ad == 4'd7);
    if (s) m_flag = 1; else if (c) m_flag = 0;
    if (a && w) begin
      if (ad == 4'd3) m_min = wd;
      if (ad == 4'd5) m_hour = wd;
      if (ad == 4'd7) m_day = wd & 8'h87;
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] ad, input logic [7:0] wd, input string tag);
    step(1, 1, ad, wd, 8'h00, 8'h00, 8'h00, 0, 0, tag);
  endtask
  task automatic rd(input logic [3:0] ad, input string tag);
    step(1, 0, ad, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0, tag);
  endtask
  task automatic tick(input logic [7:0] mi, input logic [7:0] hr, input logic [7:0] dy,
                      input bit e, input bit r, input string tag);
    step(0, 0, 4'd0, 8'h00, mi, hr, dy, e, r, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'd3, "R1"); rd(4'd5, "R1"); rd(4'd7, "R1");
    // R2 storage and day field trimming
    wr(4'd7, 8'hFF, "R2"); rd(4'd7, "R2");
    wr(4'd3, 8'hA5, "R2"); rd(4'd3, "R2");
    // R3 stray address
    wr(4'd4, 8'h5A, "R3"); rd(4'd4, "R3"); rd(4'd3, "R3"); rd(4'd5, "R3");
    // R4 full match; minute and hour masks set but day mask clear
    wr(4'd3, 8'hB0, "R4"); wr(4'd5, 8'h88, "R4"); wr(4'd7, 8'h03, "R4");
    tick(8'h30, 8'h08, 8'h02, 1, 0, "R4");
    tick(8'h31, 8'h08, 8'h03, 1, 0, "R4");
    tick(8'h30, 8'h08, 8'h03, 0, 1, "R4");
    tick(8'h30, 8'h08, 8'h03, 1, 0, "R4");
    tick(8'h00, 8'h00, 8'h00, 0, 0, "R9");
    tick(8'h00, 8'h00, 8'h00, 0, 0, "R9");
    // R3 stray access keeps flag
    rd(4'd6, "R3"); tick(8'h00, 8'h00, 8'h00, 0, 0, "R3");
    // R10 read clears
    rd(4'd5, "R10"); tick(8'h00, 8'h00, 8'h00, 0, 0, "R10");
    // R5 daily
    wr(4'd5, 8'h08, "R5"); wr(4'd7, 8'h81, "R5");
    tick(8'h30, 8'h08, 8'h05, 1, 0, "R5");
    tick(8'h00, 8'h00, 8'h00, 0, 0, "R5");
    wr(4'd3, 8'h30, "R10");
    tick(8'h30, 8'h09, 8'h05, 1, 0, "R5");
    tick(8'h00, 8'h00, 8'h00, 0, 0, "R5");
    // R8 hour mode bits: stored 12h AM 12 (0x52)
    wr(4'd5, 8'h52, "R8");
    tick(8'h30, 8'h72, 8'h01, 1, 0, "R8");
    tick(8'h30, 8'h12, 8'h01, 1, 0, "R8");
    tick(8'h30, 8'h52, 8'h01, 1, 0, "R8");
    tick(8'h00, 8'h00, 8'h00, 0, 0, "R8");
    // R10 same-cycle set wins over clearing read
    step(1, 0, 4'd3, 8'h00, 8'h30, 8'h52, 8'h01, 1, 0, "R10");
    tick(8'h00, 8'h00, 8'h00, 0, 0, "R10");
    rd(4'd7, "R10"); tick(8'h00, 8'h00, 8'h00, 0, 0, "R10");
    // R6 hourly
    wr(4'd5, 8'h80, "R6"); wr(4'd3, 8'h45, "R6");
    tick(8'h45, 8'h23, 8'h06, 0, 1, "R6");
    tick(8'h44, 8'h23, 8'h06, 1, 0, "R6");
    tick(8'h45, 8'h23, 8'h06, 1, 0, "R6");
    tick(8'h00, 8'h00, 8'h00, 0, 0, "R6");
    // R7 per minute
    wr(4'd3, 8'hC5, "R7");
    tick(8'h45, 8'h00, 8'h00, 1, 0, "R7");
    tick(8'h45, 8'h00, 8'h00, 1, 0, "R7");
    tick(8'h11, 8'h00, 8'h00, 0, 1, "R7");
    tick(8'h00, 8'h00, 8'h00, 0, 0, "R7");
    // random mix against the model
    for (int i = 0; i < 400; i++) begin
      logic [3:0] ra = 4'($urandom_range(2, 8));
      logic [7:0] rw = 8'($urandom);
      logic [7:0] mi = ($urandom_range(0, 1) != 0) ? m_min : 8'h21;
      logic [7:0] hr = ($urandom_range(0, 1) != 0) ? m_hour : 8'h47;
      logic [7:0] dy = ($urandom_range(0, 1) != 0) ? m_day : 8'h04;
      step($urandom_range(0, 3) == 0, $urandom_range(0, 1) != 0, ra, rw,
           mi & 8'h7F, hr & 8'h7F, dy & 8'h07,
           $urandom_range(0, 1) != 0, $urandom_range(0, 3) == 0, "R10");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule